// File: doc/BRIEF.md
# Serial Clock-Chip Host Port

This block is the host-side register for a real-time-clock chip that software drives one bit at a time. Software writes a single control byte that carries a command code, a strobe line, a shift clock and a serial data bit. The block works out the edges of the strobe and the shift clock by comparing each new byte with the byte stored before it. It then decodes the command and moves data through two shift registers.

A read-time command loads a 52-bit output shift register from parallel time-of-day inputs. Each falling edge of the shift clock moves that register right by one bit, and software reads the low bit back through a status byte. The same clock edges feed a small command shifter that supplies an extended command when the short command code asks for one. A separate mode register selects whether the loaded frame is moved up by one nibble. The block does not keep time: the time fields arrive on input ports.

Top module: `serclk_host`

## Requirements
- R1: After reset the status byte reads 0xF8, the mode register reads 0xFF and the latched command reads 0.
- R2: A write with `wr_sel`=1 stores `wr_data` into the mode register, and `mode_q` shows it from the next cycle. A control write leaves it unchanged.
- R3: A control write whose bit 3 (strobe) is 0 while the stored previous byte had bit 3 set latches bits 2:0 of the previous byte as the command. With no such falling edge the command is held.
- R4: A latched command of 3 loads the output shift register with the frame {year BCD [47:40], month binary [39:36], weekday [35:32], day BCD [31:24], hours BCD [23:16], minutes BCD [15:8], seconds BCD [7:0]}.
- R5: When mode bit 5 is set at load time, the frame is loaded shifted left by 4 bits, so bits 3:0 of the register are zero. When mode bit 5 is clear it is loaded unshifted.
- R6: A control write whose bit 4 (shift clock) is 0 while the previous byte had bit 4 set shifts the 52-bit output register right by one, with zero entering at the top.
- R7: On the same shift-clock falling edge, bit 5 (data in) of the previous byte enters the 4-bit extended command shifter at bit 3, and the shifter moves right by one.
- R8: A strobe falling edge with previous command bits equal to 7 latches the 4-bit extended shifter value as the command. If that value is 3, the time is loaded as in R4.
- R9: Latched commands other than 3, and an extended value other than 3, leave the output shift register unchanged.
- R10: The status byte is 0xF8 with bit 0 equal to bit 0 of the output shift register.
- R11: When one write makes both the strobe and the shift clock fall, the load happens first and is followed by one shift. The extended command is taken from the shifter value before that write's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 1 | 0 = control byte, 1 = mode register |
| wr_data | input | 8 | Write data |
| tod_sec | input | 8 | Seconds, BCD |
| tod_min | input | 8 | Minutes, BCD |
| tod_hour | input | 8 | Hours, BCD |
| tod_mday | input | 8 | Day of month, BCD |
| tod_wday | input | 4 | Weekday 0-6 |
| tod_mon | input | 4 | Month 1-12, binary |
| tod_year | input | 8 | Two-digit year, BCD |
| status_q | output | 8 | Status byte with serial output bit |
| mode_q | output | 8 | Mode register readback |
| cmd_q | output | 4 | Latched command |

## Verification
The bench steers the extended-command path by clocking a known pattern through the data-in bit and then sending command 7. A design that inserted the bit at the wrong end, or used the post-shift value, would latch a command other than 3 and fail to load the time. It also sends a single write that drops the strobe and the clock together. A design that shifted before loading would show seconds bit 0 instead of bit 1 on the status byte. Long runs of 52 and more shift pulses in both layouts catch a register that wraps or fills with ones, and a wrong nibble offset. Random control and mode bytes check that non-read commands never disturb the output register and that edges are taken against the stored previous byte.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  localparam int BYTE_W    = 8;
  localparam int CMD_W     = 3;
  localparam int ECMD_W    = 4;
  localparam int STB_BIT   = 3;
  localparam int SCK_BIT   = 4;
  localparam int DIN_BIT   = 5;
  localparam int MODE_EXT  = 5;
  localparam logic [ECMD_W-1:0] CMD_READ = 4'd3;
  localparam logic [CMD_W-1:0]  CMD_EXT  = 3'd7;
  localparam logic [BYTE_W-1:0] STATUS_BASE = 8'hF8;
  localparam logic [BYTE_W-1:0] MODE_RST    = 8'hFF;

  typedef struct packed {
    logic strobe_fall;
    logic sck_fall;
    logic din;
  } edges_t;
endpackage

// File: rtl/serclk_decode.sv
module serclk_decode
  import serclk_pkg::*;
(
  input  logic              wr_ctl,
  input  logic [BYTE_W-1:0] prev_ctl,
  input  logic [BYTE_W-1:0] new_ctl,
  input  logic [ECMD_W-1:0] ext_cmd,
  output edges_t            edges,
  output logic              cmd_en,
  output logic [ECMD_W-1:0] cmd_next,
  output logic              time_load
);
  always_comb begin
    edges.strobe_fall = wr_ctl & prev_ctl[STB_BIT] & ~new_ctl[STB_BIT];
    edges.sck_fall    = wr_ctl & prev_ctl[SCK_BIT] & ~new_ctl[SCK_BIT];
    edges.din         = prev_ctl[DIN_BIT];
    cmd_en            = edges.strobe_fall;
    if (prev_ctl[CMD_W-1:0] == CMD_EXT) begin
      cmd_next = ext_cmd;
    end else begin
      cmd_next = {{(ECMD_W-CMD_W){1'b0}}, prev_ctl[CMD_W-1:0]};
    end
    time_load = cmd_en & (cmd_next == CMD_READ);
  end
endmodule

// File: rtl/serclk_cmdsh.sv
module serclk_cmdsh #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (shift_en) begin
      q_next = {din, q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (shift_en) begin
      q <= q_next;
    end
  end
endmodule

// File: rtl/serclk_outsr.sv
module serclk_outsr #(
  parameter int FRAME_W  = 48,
  parameter int ALIGN_SH = 4,
  localparam int SR_W    = FRAME_W + ALIGN_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift_en,
  input  logic               align,
  input  logic [FRAME_W-1:0] frame,
  output logic [SR_W-1:0]    sr_q
);
  logic [SR_W-1:0] loaded;
  logic [SR_W-1:0] sr_next;
  logic [SR_W-1:0] frame_wide;

  generate
    if (ALIGN_SH > 0) begin : g_align
      always_comb begin
        frame_wide = {{ALIGN_SH{1'b0}}, frame};
        if (align) begin
          frame_wide = {frame, {ALIGN_SH{1'b0}}};
        end
      end
    end else begin : g_noalign
      always_comb frame_wide = frame;
    end
  endgenerate

  always_comb begin
    loaded  = load ? frame_wide : sr_q;
    sr_next = shift_en ? {1'b0, loaded[SR_W-1:1]} : loaded;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load || shift_en) begin
      sr_q <= sr_next;
    end
  end
endmodule

// File: rtl/serclk_host.sv
module serclk_host
  import serclk_pkg::*;
#(
  parameter int FRAME_W  = 48,
  parameter int ALIGN_SH = 4,
  localparam int SR_W    = FRAME_W + ALIGN_SH
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [7:0]  wr_data,
  input  logic [7:0]  tod_sec,
  input  logic [7:0]  tod_min,
  input  logic [7:0]  tod_hour,
  input  logic [7:0]  tod_mday,
  input  logic [3:0]  tod_wday,
  input  logic [3:0]  tod_mon,
  input  logic [7:0]  tod_year,
  output logic [7:0]  status_q,
  output logic [7:0]  mode_q,
  output logic [3:0]  cmd_q
);
  logic [BYTE_W-1:0] ctrl_q;
  logic [ECMD_W-1:0] ext_q;
  logic [SR_W-1:0]   sr_bits;
  logic [FRAME_W-1:0] frame;
  edges_t            edges;
  logic              cmd_en;
  logic [ECMD_W-1:0] cmd_next;
  logic              time_load;
  logic              wr_ctl;
  logic              wr_mode;

  assign wr_ctl  = wr_en & ~wr_sel;
  assign wr_mode = wr_en & wr_sel;

  always_comb begin
    frame = '0;
    frame[47:0] = {tod_year, tod_mon, tod_wday, tod_mday, tod_hour, tod_min, tod_sec};
  end

  serclk_decode u_decode (
    .wr_ctl    (wr_ctl),
    .prev_ctl  (ctrl_q),
    .new_ctl   (wr_data),
    .ext_cmd   (ext_q),
    .edges     (edges),
    .cmd_en    (cmd_en),
    .cmd_next  (cmd_next),
    .time_load (time_load)
  );

  serclk_cmdsh #(.W(ECMD_W)) u_cmdsh (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (edges.sck_fall),
    .din      (edges.din),
    .q        (ext_q)
  );

  serclk_outsr #(.FRAME_W(FRAME_W), .ALIGN_SH(ALIGN_SH)) u_outsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (time_load),
    .shift_en (edges.sck_fall),
    .align    (mode_q[MODE_EXT]),
    .frame    (frame),
    .sr_q     (sr_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctl) begin
      ctrl_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
    end else if (wr_mode) begin
      mode_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_next;
    end
  end

  assign status_q = STATUS_BASE | {7'd0, sr_bits[0]};
endmodule

// File: rtl/serclk_host_chk.sv
module serclk_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [7:0]  wr_data,
  input logic [7:0]  ctrl_q,
  input logic [3:0]  ext_q,
  input logic [51:0] sr_bits,
  input logic [7:0]  status_q,
  input logic [7:0]  mode_q,
  input logic [3:0]  cmd_q
);
  logic stb_fall;
  logic sck_fall;
  assign stb_fall = wr_en && !wr_sel && ctrl_q[3] && !wr_data[3];
  assign sck_fall = wr_en && !wr_sel && ctrl_q[4] && !wr_data[4];

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (mode_q == $past(wr_data)));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(mode_q));

  assert_cmd_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && ctrl_q[2:0] != 3'd7) |=> (cmd_q == {1'b0, $past(ctrl_q[2:0])}));

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_fall |=> $stable(cmd_q));

  assert_ext_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && ctrl_q[2:0] == 3'd7) |=> (cmd_q == $past(ext_q)));

  assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && !stb_fall) |=> (sr_bits == ($past(sr_bits) >> 1)));

  assert_status_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !stb_fall) |=> $stable(status_q));
endmodule

bind serclk_host serclk_host_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .ctrl_q   (ctrl_q),
  .ext_q    (ext_q),
  .sr_bits  (sr_bits),
  .status_q (status_q),
  .mode_q   (mode_q),
  .cmd_q    (cmd_q)
);

// File: tb/test_serclk_host.sv
module test_serclk_host;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [7:0]  wr_data;
  logic [7:0]  tod_sec, tod_min, tod_hour, tod_mday, tod_year;
  logic [3:0]  tod_wday, tod_mon;
  logic [7:0]  status_q, mode_q;
  logic [3:0]  cmd_q;

  int checks;
  int errors;
  bit done;

  logic [7:0]  m_prev;
  logic [3:0]  m_ext;
  logic [51:0] m_sr;
  logic [3:0]  m_cmd;
  logic [7:0]  m_mode;

  serclk_host i_serclk_host (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour), .tod_mday(tod_mday),
    .tod_wday(tod_wday), .tod_mon(tod_mon), .tod_year(tod_year),
    .status_q(status_q), .mode_q(mode_q), .cmd_q(cmd_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [51:0] exp_frame(input logic ext);
    logic [51:0] f;
    f = {4'd0, tod_year, tod_mon, tod_wday, tod_mday, tod_hour, tod_min, tod_sec};
    if (ext) f = f << 4;
    return f;
  endfunction

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check(req, {24'd0, status_q}, {24'd0, 8'hF8 | {7'd0, m_sr[0]}});
    check(req, {28'd0, cmd_q}, {28'd0, m_cmd});
    check(req, {24'd0, mode_q}, {24'd0, m_mode});
  endtask

  task automatic do_write(input logic sel, input logic [7:0] d);
    logic [3:0] c;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    if (sel) begin
      m_mode = d;
    end else begin
      if (m_prev[3] && !d[3]) begin
        c = {1'b0, m_prev[2:0]};
        if (c == 4'd7) c = m_ext;
        m_cmd = c;
        if (c == 4'd3) m_sr = exp_frame(m_mode[5]);
      end
      if (m_prev[4] && !d[4]) begin
        m_ext = {m_prev[5], m_ext[3:1]};
        m_sr  = m_sr >> 1;
      end
      m_prev = d;
    end
  endtask

  task automatic rand_time();
    tod_sec  = bcd($urandom_range(0, 59));
    tod_min  = bcd($urandom_range(0, 59));
    tod_hour = bcd($urandom_range(0, 23));
    tod_mday = bcd($urandom_range(1, 31));
    tod_wday = 4'($urandom_range(0, 6));
    tod_mon  = 4'($urandom_range(1, 12));
    tod_year = bcd($urandom_range(0, 99));
  endtask

  task automatic clock_bit(input logic b);
    do_write(1'b0, {2'b00, b, 5'b10000});
    do_write(1'b0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    checks = 0; errors = 0; done = 1'b0;
    void'($urandom(1234));
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    tod_sec = 8'h37; tod_min = 8'h42; tod_hour = 8'h19; tod_mday = 8'h28;
    tod_wday = 4'd5; tod_mon = 4'd11; tod_year = 8'h09;
    m_prev = 8'h00; m_ext = 4'h0; m_sr = '0; m_cmd = 4'h0; m_mode = 8'hFF;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", {24'd0, status_q}, 32'hF8);
    check("R1 mode",   {24'd0, mode_q},   32'hFF);
    check("R1 cmd",    {28'd0, cmd_q},    32'h0);

    // R2 mode write, control write leaves it alone
    do_write(1'b1, 8'h00);
    check("R2 mode", {24'd0, mode_q}, 32'h00);
    do_write(1'b0, 8'h20);
    check("R2 mode hold", {24'd0, mode_q}, 32'h00);

    // R3/R4 plain layout read: seconds 0x37, bit0 = 1
    do_write(1'b0, 8'h0B);
    check("R3 no fall yet", {28'd0, cmd_q}, 32'h0);
    do_write(1'b0, 8'h00);
    check("R3 cmd", {28'd0, cmd_q}, 32'h3);
    check("R4 bit0", {31'd0, status_q[0]}, 32'h1);
    for (int i = 0; i < 60; i++) begin
      clock_bit(1'b0);
      compare_all("R6 shift plain");
    end
    check("R6 zero fill", {31'd0, status_q[0]}, 32'h0);

    // R5 extended layout: low nibble zero, then seconds
    do_write(1'b1, 8'h20);
    do_write(1'b0, 8'h0B);
    do_write(1'b0, 8'h00);
    for (int i = 0; i < 4; i++) begin
      check("R5 low nibble", {31'd0, status_q[0]}, 32'h0);
      clock_bit(1'b0);
    end
    check("R5 seconds bit0", {31'd0, status_q[0]}, 32'h1);
    for (int i = 0; i < 52; i++) begin
      clock_bit(1'b0);
      compare_all("R6 shift ext");
    end

    // R9 non-read command leaves register
    do_write(1'b1, 8'h00);
    do_write(1'b0, 8'h0B);
    do_write(1'b0, 8'h00);
    do_write(1'b0, 8'h09);
    do_write(1'b0, 8'h00);
    check("R9 cmd1", {28'd0, cmd_q}, 32'h1);
    check("R9 bit0 kept", {31'd0, status_q[0]}, 32'h1);

    // R7/R8 extended command 3 via shifter: bits 1,1,0,0
    clock_bit(1'b1); clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b0);
    tod_sec = 8'h50;
    do_write(1'b0, 8'h0F);
    do_write(1'b0, 8'h00);
    check("R8 ext cmd", {28'd0, cmd_q}, 32'h3);
    check("R7 R8 loaded", {31'd0, status_q[0]}, 32'h0);
    compare_all("R8 model");

    // R8 extended value other than 3 does not load
    clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b1); clock_bit(1'b0);
    tod_sec = 8'h51;
    do_write(1'b0, 8'h0F);
    do_write(1'b0, 8'h00);
    check("R8 ext cmd 5", {28'd0, cmd_q}, 32'h5);
    compare_all("R9 ext no load");

    // R11 strobe and clock fall together: load then shift; seconds 0x12 -> bit1 = 1
    tod_sec = 8'h12;
    do_write(1'b0, 8'h1B);
    do_write(1'b0, 8'h00);
    check("R11 load then shift", {31'd0, status_q[0]}, 32'h1);
    compare_all("R11 model");

    // Random mix, R10 format and all rules against the model
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 15) == 0) rand_time();
      d = 8'($urandom);
      if ($urandom_range(0, 9) == 0) begin
        do_write(1'b1, d);
      end else begin
        do_write(1'b0, d);
      end
      compare_all("R10 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule